// File: doc/BRIEF.md
# Programmable ISA I/O Pin Decoder

This block drives one general-purpose pin on an ISA-style peripheral. Depending on a configuration byte, the pin works in one of two ways. It can be a chip select that decodes an 11-bit I/O address, optionally qualified by the read strobe, the write strobe or either one, with selectable polarity. It can also be a one-bit data port tied to bus line SD0, with independent inversion on the pin-to-bus path and on the bus-to-pin path. Every other mode value tri-states the pin.

The configuration byte sits behind an index/data port pair. Writes to it are accepted only after the configuration space has been unlocked with a fixed key sequence. The 11-bit decode address comes in as a plain input from a neighbouring base-address register. All bus inputs are sampled on the system clock, and every result is registered. The configuration port and the bus pins are plain control signals with no handshake, because each bus access completes in a single sampled cycle and the block never needs to stall it.

Top module: `isa_gpio_pin`

## Requirements
- R1: After reset the configuration byte is 00h, so the pin is a chip select that is active low and has no qualifier. In this state pin_oe is 1, pin_out is 1 when idle, and sd0_oe is 0.
- R2: A write to the index port (cfg_port=0) of 87h, followed at once by another index write of 87h, unlocks configuration. While unlocked, an index write of AAh locks it again and any other index byte is stored as the index. A data-port write (cfg_port=1) updates the configuration byte only while unlocked and with index 15h. Every other configuration write leaves the byte unchanged.
- R3: With configuration bits 3 and 2 both 0, the select is active one clock after a cycle in which aen is 0 and sa equals base_addr, whatever the strobes are.
- R4: With bit 2 set and bit 3 clear, the select additionally needs iow_n to be 0.
- R5: With bit 3 set and bit 2 clear, the select additionally needs ior_n to be 0.
- R6: With bits 3 and 2 both set, the select additionally needs iow_n or ior_n to be 0.
- R7: In chip-select mode, bit 4 = 0 drives pin_out low while selected and high otherwise. Bit 4 = 1 does the reverse.
- R8: The select is never active for a cycle with aen at 1 or with sa different from base_addr.
- R9: Bits 7:5 give the mode. 000 is chip select and 001 is data, and both drive pin_oe to 1. Every other value gives pin_oe = 0 and pin_out = 0.
- R10: In data mode, pin_out takes sd0_in XOR configuration bit 1 at the clock edge where iow_n is first seen high after being low, provided aen is 0 and sa matches at that edge. Write cycles with aen high or a mismatched address leave pin_out unchanged.
- R11: In data mode, sd0_oe is 1 one clock after a cycle with ior_n = 0, aen = 0 and a matching address, and 0 otherwise. sd0_out is then pin_in XOR configuration bit 0. Outside data mode, sd0_oe stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe, one cycle per write |
| cfg_port | input | 1 | 0 selects the index port, 1 selects the data port |
| cfg_wdata | input | 8 | Configuration write byte |
| base_addr | input | 11 | Decode match address |
| aen | input | 1 | Address enable; high means a DMA cycle and blocks decode |
| sa | input | 11 | ISA address bits 10:0 |
| ior_n | input | 1 | Active-low I/O read strobe |
| iow_n | input | 1 | Active-low I/O write strobe |
| sd0_in | input | 1 | Bus data bit 0 from the host |
| pin_in | input | 1 | Level sensed at the pin |
| pin_out | output | 1 | Value driven onto the pin |
| pin_oe | output | 1 | Pin output enable |
| sd0_out | output | 1 | Value driven onto bus bit 0 |
| sd0_oe | output | 1 | Bus bit 0 output enable |

## Verification
A configuration write takes effect at the clock edge that samples cfg_wr, so the next bus stimulus already sees the new byte. The chip select, sd0_oe and sd0_out each have one register on their path. The bench therefore drives bus pins on a falling edge and samples 2 ns after the next rising edge. The data-mode latch needs two edges, one that sees iow_n low and one that sees it high again, and its result is read 2 ns after the second. Each scenario also returns the bus to idle and checks one edge later that the registered outputs have dropped.

// File: rtl/isa_gpio_pkg.sv
`timescale 1ns/1ps
package isa_gpio_pkg;

  localparam logic [2:0] MODE_CS   = 3'b000;
  localparam logic [2:0] MODE_DATA = 3'b001;

  typedef struct packed {
    logic [2:0] mode;
    logic       cs_high;
    logic       qual_rd;
    logic       qual_wr;
    logic       inv_out;
    logic       inv_in;
  } pin_cfg_t;

  localparam int CFG_BITS = $bits(pin_cfg_t);

  typedef enum logic [1:0] {
    UL_LOCKED = 2'd0,
    UL_HALF   = 2'd1,
    UL_OPEN   = 2'd2
  } unlock_e;

endpackage

// File: rtl/isa_gpio_cfg.sv
`timescale 1ns/1ps
module isa_gpio_cfg
  import isa_gpio_pkg::*;
#(
  parameter int          DATA_W     = 8,
  parameter logic [7:0]  CFG_INDEX  = 8'h15,
  parameter logic [7:0]  UNLOCK_KEY = 8'h87,
  parameter logic [7:0]  EXIT_KEY   = 8'hAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              port,
  input  logic [DATA_W-1:0] wdata,
  output pin_cfg_t          cfg
);

  unlock_e           state;
  logic [DATA_W-1:0] index_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= UL_LOCKED;
      index_q <= '0;
      cfg     <= '0;
    end else if (wr) begin
      unique case (state)
        UL_LOCKED: if (!port && wdata == UNLOCK_KEY) state <= UL_HALF;
        UL_HALF:   state <= (!port && wdata == UNLOCK_KEY) ? UL_OPEN : UL_LOCKED;
        UL_OPEN: begin
          if (!port) begin
            if (wdata == EXIT_KEY) state <= UL_LOCKED;
            else                   index_q <= wdata;
          end else if (index_q == CFG_INDEX) begin
            cfg <= pin_cfg_t'(wdata[CFG_BITS-1:0]);
          end
        end
        default:   state <= UL_LOCKED;
      endcase
    end
  end

  // R2: outside the unlocked state nothing reaches the configuration byte
  assert_locked_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state != UL_OPEN) |=> $stable(cfg));

  // R2: the data port never moves the unlock state machine forward
  assert_data_no_unlock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && port && state == UL_LOCKED) |=> (state == UL_LOCKED));

endmodule

// File: rtl/isa_gpio_decode.sv
`timescale 1ns/1ps
module isa_gpio_decode #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              aen,
  input  logic [ADDR_W-1:0] sa,
  input  logic [ADDR_W-1:0] base,
  input  logic              ior_n,
  input  logic              iow_n,
  input  logic              qual_rd,
  input  logic              qual_wr,
  output logic              hit,
  output logic              sel_q
);

  logic strobe_ok;

  assign hit = !aen && (sa == base);

  always_comb begin
    unique case ({qual_rd, qual_wr})
      2'b00:   strobe_ok = 1'b1;
      2'b01:   strobe_ok = !iow_n;
      2'b10:   strobe_ok = !ior_n;
      default: strobe_ok = !iow_n || !ior_n;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= 1'b0;
    else        sel_q <= hit && strobe_ok;
  end

  assert_plain_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!aen && sa == base && !qual_rd && !qual_wr) |=> sel_q);

  assert_wr_qual_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (qual_wr && !qual_rd && iow_n) |=> !sel_q);

  assert_rd_qual_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (qual_rd && !qual_wr && ior_n) |=> !sel_q);

  assert_either_qual_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (qual_rd && qual_wr && ior_n && iow_n) |=> !sel_q);

  assert_aen_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    aen |=> !sel_q);

  assert_mismatch_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sa != base) |=> !sel_q);

endmodule

// File: rtl/isa_gpio_datapath.sv
`timescale 1ns/1ps
module isa_gpio_datapath (
  input  logic clk,
  input  logic rst_n,
  input  logic data_mode,
  input  logic hit,
  input  logic ior_n,
  input  logic iow_n,
  input  logic sd0_in,
  input  logic pin_in,
  input  logic inv_out,
  input  logic inv_in,
  output logic pin_q,
  output logic sd0_out,
  output logic sd0_oe
);

  logic iow_q;
  logic wr_edge;

  assign wr_edge = data_mode && hit && !iow_q && iow_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iow_q   <= 1'b1;
      pin_q   <= 1'b0;
      sd0_out <= 1'b0;
      sd0_oe  <= 1'b0;
    end else begin
      iow_q   <= iow_n;
      if (wr_edge) pin_q <= sd0_in ^ inv_out;
      sd0_out <= pin_in ^ inv_in;
      sd0_oe  <= data_mode && hit && !ior_n;
    end
  end

  // R10: the latch moves only on a qualified rising write edge
  assert_latch_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit || !data_mode) |=> $stable(pin_q));

  assert_latch_value_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_edge |=> (pin_q == $past(sd0_in ^ inv_out)));

  // R11: no bus drive without a matched read in data mode
  assert_sd0_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ior_n || !hit || !data_mode) |=> !sd0_oe);

endmodule

// File: rtl/isa_gpio_pin.sv
`timescale 1ns/1ps
module isa_gpio_pin
  import isa_gpio_pkg::*;
#(
  parameter int         ADDR_W     = 11,
  parameter int         DATA_W     = 8,
  parameter logic [7:0] CFG_INDEX  = 8'h15,
  parameter logic [7:0] UNLOCK_KEY = 8'h87,
  parameter logic [7:0] EXIT_KEY   = 8'hAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_port,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              aen,
  input  logic [ADDR_W-1:0] sa,
  input  logic              ior_n,
  input  logic              iow_n,
  input  logic              sd0_in,
  input  logic              pin_in,
  output logic              pin_out,
  output logic              pin_oe,
  output logic              sd0_out,
  output logic              sd0_oe
);

  pin_cfg_t cfg;
  logic     hit;
  logic     sel_q;
  logic     pin_q;
  logic     data_mode;

  assign data_mode = (cfg.mode == MODE_DATA);

  isa_gpio_cfg #(
    .DATA_W(DATA_W), .CFG_INDEX(CFG_INDEX),
    .UNLOCK_KEY(UNLOCK_KEY), .EXIT_KEY(EXIT_KEY)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .port(cfg_port),
    .wdata(cfg_wdata), .cfg(cfg)
  );

  isa_gpio_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .aen(aen), .sa(sa), .base(base_addr),
    .ior_n(ior_n), .iow_n(iow_n), .qual_rd(cfg.qual_rd),
    .qual_wr(cfg.qual_wr), .hit(hit), .sel_q(sel_q)
  );

  isa_gpio_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .data_mode(data_mode), .hit(hit),
    .ior_n(ior_n), .iow_n(iow_n), .sd0_in(sd0_in), .pin_in(pin_in),
    .inv_out(cfg.inv_out), .inv_in(cfg.inv_in), .pin_q(pin_q),
    .sd0_out(sd0_out), .sd0_oe(sd0_oe)
  );

  always_comb begin
    unique case (cfg.mode)
      MODE_CS: begin
        pin_oe  = 1'b1;
        pin_out = cfg.cs_high ? sel_q : !sel_q;
      end
      MODE_DATA: begin
        pin_oe  = 1'b1;
        pin_out = pin_q;
      end
      default: begin
        pin_oe  = 1'b0;
        pin_out = 1'b0;
      end
    endcase
  end

  assert_off_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode != MODE_CS && cfg.mode != MODE_DATA) |-> (!pin_oe && !pin_out));

  assert_idle_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode == MODE_CS && !sel_q) |-> (pin_out == !cfg.cs_high));

  assert_cs_no_drive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode == MODE_CS) |=> !sd0_oe);

endmodule

// File: tb/isa_gpio_pin_test.sv
`timescale 1ns/1ps
module isa_gpio_pin_test;

  localparam real CLK_NS = 8.0;
  localparam logic [10:0] BASE = 11'h2A5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0, cfg_port = 1'b0;
  logic [7:0]  cfg_wdata = 8'h00;
  logic        aen = 1'b1, ior_n = 1'b1, iow_n = 1'b1, sd0_in = 1'b0, pin_in = 1'b0;
  logic [10:0] sa = 11'h000;
  logic        pin_out, pin_oe, sd0_out, sd0_oe;
  int          checks = 0, failures = 0;
  bit          done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  isa_gpio_pin uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_port(cfg_port),
    .cfg_wdata(cfg_wdata), .base_addr(BASE), .aen(aen), .sa(sa),
    .ior_n(ior_n), .iow_n(iow_n), .sd0_in(sd0_in), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .sd0_out(sd0_out), .sd0_oe(sd0_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic port, input logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_port = port; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic set_cfg(input logic [7:0] v);
    cfg_write(1'b0, 8'h87);
    cfg_write(1'b0, 8'h87);
    cfg_write(1'b0, 8'h15);
    cfg_write(1'b1, v);
    cfg_write(1'b0, 8'hAA);
  endtask

  // drive one bus cycle at a falling edge, then wait for the sampling edge
  task automatic bus(input logic a, input logic [10:0] addr, input logic r_n, input logic w_n);
    @(negedge clk);
    aen = a; sa = addr; ior_n = r_n; iow_n = w_n;
    @(posedge clk); #2;
  endtask

  task automatic idle();
    bus(1'b1, 11'h000, 1'b1, 1'b1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    chk("R1 pin_oe after reset", {7'd0, pin_oe}, 8'h01);
    chk("R1 idle level active-low select", {7'd0, pin_out}, 8'h01);
    chk("R1 sd0_oe after reset", {7'd0, sd0_oe}, 8'h00);
    bus(1'b0, BASE, 1'b1, 1'b1);
    chk("R1 default unqualified select", {7'd0, pin_out}, 8'h00);
    idle();
  endtask

  task automatic t_unlock();
    cfg_write(1'b0, 8'h15); cfg_write(1'b1, 8'h40);
    idle();
    chk("R2 locked data write ignored", {7'd0, pin_oe}, 8'h01);
    cfg_write(1'b0, 8'h87); cfg_write(1'b1, 8'h40);
    idle();
    chk("R2 single key then data ignored", {7'd0, pin_oe}, 8'h01);
    cfg_write(1'b0, 8'h87); cfg_write(1'b0, 8'h87);
    cfg_write(1'b0, 8'h14); cfg_write(1'b1, 8'h40); cfg_write(1'b0, 8'hAA);
    idle();
    chk("R2 wrong index ignored", {7'd0, pin_oe}, 8'h01);
    set_cfg(8'h40);
    idle();
    chk("R2 unlocked write takes effect", {7'd0, pin_oe}, 8'h00);
    cfg_write(1'b1, 8'h00);
    idle();
    chk("R2 exit key relocks", {7'd0, pin_oe}, 8'h00);
  endtask

  task automatic t_qualifiers();
    for (int q = 0; q < 4; q++) begin
      string tag;
      tag = (q == 0) ? "R3" : (q == 1) ? "R4" : (q == 2) ? "R5" : "R6";
      set_cfg({3'b000, 1'b1, q[1], q[0], 2'b00});
      for (int p = 0; p < 3; p++) begin
        logic exp;
        exp = (q == 0) ? 1'b1 : (q == 1) ? (p == 1) : (q == 2) ? (p == 2) : (p != 0);
        bus(1'b0, BASE, !(p == 2), !(p == 1));
        chk($sformatf("%s qual=%0d strobe=%0d", tag, q, p), {7'd0, pin_out}, {7'd0, exp});
        idle();
        chk($sformatf("%s release qual=%0d", tag, q), {7'd0, pin_out}, 8'h00);
      end
    end
  endtask

  task automatic t_polarity();
    set_cfg(8'h00);
    idle();
    chk("R7 low-active idle", {7'd0, pin_out}, 8'h01);
    bus(1'b0, BASE, 1'b1, 1'b1);
    chk("R7 low-active selected", {7'd0, pin_out}, 8'h00);
    set_cfg(8'h10);
    idle();
    chk("R7 high-active idle", {7'd0, pin_out}, 8'h00);
    bus(1'b0, BASE, 1'b1, 1'b1);
    chk("R7 high-active selected", {7'd0, pin_out}, 8'h01);
    idle();
  endtask

  task automatic t_miss();
    set_cfg(8'h1C);
    bus(1'b1, BASE, 1'b0, 1'b0);
    chk("R8 aen high blocks", {7'd0, pin_out}, 8'h00);
    bus(1'b0, BASE ^ 11'h001, 1'b0, 1'b0);
    chk("R8 low bit mismatch", {7'd0, pin_out}, 8'h00);
    bus(1'b0, BASE ^ 11'h400, 1'b0, 1'b0);
    chk("R8 top bit mismatch", {7'd0, pin_out}, 8'h00);
    idle();
  endtask

  task automatic t_modes();
    for (int m = 0; m < 8; m++) begin
      set_cfg({m[2:0], 5'b10000});
      bus(1'b0, BASE, 1'b1, 1'b1);
      chk($sformatf("R9 pin_oe mode=%0d", m), {7'd0, pin_oe}, {7'd0, (m < 2)});
      if (m >= 2) chk($sformatf("R9 pin_out mode=%0d", m), {7'd0, pin_out}, 8'h00);
      idle();
    end
  endtask

  task automatic write_cycle(input logic a, input logic [10:0] addr, input logic d);
    @(negedge clk);
    aen = a; sa = addr; iow_n = 1'b0; sd0_in = d;
    @(negedge clk);
    iow_n = 1'b1;
    @(posedge clk); #2;
  endtask

  task automatic t_inversion();
    for (int k = 0; k < 4; k++) begin
      set_cfg({3'b001, 3'b000, k[1], k[0]});
      for (int v = 0; v < 2; v++) begin
        write_cycle(1'b0, BASE, v[0]);
        chk($sformatf("R10 latch inv=%0d v=%0d", k, v), {7'd0, pin_out}, {7'd0, v[0] ^ k[1]});
        idle();
        @(negedge clk); pin_in = v[0];
        bus(1'b0, BASE, 1'b0, 1'b1);
        chk($sformatf("R11 sd0_oe inv=%0d v=%0d", k, v), {7'd0, sd0_oe}, 8'h01);
        chk($sformatf("R11 sd0_out inv=%0d v=%0d", k, v), {7'd0, sd0_out}, {7'd0, v[0] ^ k[0]});
        idle();
        chk($sformatf("R11 sd0 release inv=%0d", k), {7'd0, sd0_oe}, 8'h00);
      end
    end
  endtask

  task automatic t_data_miss();
    set_cfg(8'h20);
    write_cycle(1'b0, BASE, 1'b1);
    chk("R10 baseline latch", {7'd0, pin_out}, 8'h01);
    write_cycle(1'b1, BASE, 1'b0);
    chk("R10 aen high write ignored", {7'd0, pin_out}, 8'h01);
    write_cycle(1'b0, BASE ^ 11'h010, 1'b0);
    chk("R10 mismatched write ignored", {7'd0, pin_out}, 8'h01);
    bus(1'b1, BASE, 1'b0, 1'b1);
    chk("R11 aen high read not driven", {7'd0, sd0_oe}, 8'h00);
    set_cfg(8'h00);
    bus(1'b0, BASE, 1'b0, 1'b1);
    chk("R11 chip-select mode read not driven", {7'd0, sd0_oe}, 8'h00);
    idle();
  endtask

  initial begin
    t_reset();
    t_unlock();
    t_qualifiers();
    t_polarity();
    t_miss();
    t_modes();
    t_inversion();
    t_data_miss();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog (all requirements) actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule